// File: doc/BRIEF.md
# Converter Serial Command and Result Port

This block is the digital serial side of a multichannel 14-bit converter. A host drives a serial clock, an active-low select and a command line. The block watches the command line for a start bit and collects the command word that follows. It then does one of four things with that word: it stores a per-channel input setting, it issues a conversion request, it changes the clock mode, or it does nothing. When the converter core signals that it has finished, the block loads the parallel result. It then shifts the result out MSB first, one bit per falling edge of the serial clock.

A new start bit may arrive while the previous result is still being read out. How far the readout must have gone before a start bit counts depends on the clock mode. This lets the next command overlap the tail of the current readout. All serial inputs are brought into the system clock domain, and all edge handling runs on that clock.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, every channel setting is single-ended with span code 0 (3x reference). The clock mode is 0, no conversion is busy, the result-output enable is low, and a start bit is accepted at once.
- R2: The command line is sampled on rising serial-clock edges while select is low. A start bit is the first 1 sampled while acceptance is enabled. Zeros and rejected ones before it are discarded.
- R3: The 8 bits after the start bit form the command. Bits [7:6] are the opcode: 01 = setting, 10 = convert, 11 = clock mode, 00 = no operation. Bits [5:3] are the channel, bit 2 is the differential flag, and bits [1:0] are the span code or the clock mode.
- R4: A setting command stores the differential flag and span for its channel. Span codes are 0 = 3x, 1 = 6x and 2 = 12x. Code 3 leaves that channel unchanged.
- R5: A convert command gives a one-cycle request pulse. The pulse carries the channel and that channel's stored flag and span. The busy output is set with the pulse and stays high until the done input arrives.
- R6: A done input while busy loads the parallel result, clears busy and gives a one-cycle ready pulse. A done input while not busy is ignored.
- R7: The result bit 13 appears on the result line when the result is loaded. Each falling serial-clock edge with select low moves to the next lower bit. The line reads 0 once all 14 bits have been sent. The code is passed through unchanged, so offset binary stays offset binary.
- R8: No start bit is accepted while a conversion is busy.
- R9: With a result pending, a start bit is accepted only after enough bits have been shifted out. The counts are 13 in mode 0, 9 in mode 1, 12 in mode 2 and 14 in mode 3.
- R10: Raising select discards a partly received command and drives the result-output enable low. Lowering select raises the enable again.
- R11: A clock-mode command sets the clock mode output to bits [1:0] of the command.
- R12: A no-operation command changes no channel setting, no mode and no conversion state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low select |
| ser_cmd | input | 1 | Serial command line |
| conv_done | input | 1 | Converter core finished |
| conv_data | input | 14 | Parallel conversion result |
| ser_res | output | 1 | Serial result line |
| ser_res_en | output | 1 | Output enable for the result line (high = driven) |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel of the request |
| conv_diff | output | 1 | Differential flag of that channel |
| conv_span | output | 2 | Span code of that channel |
| conv_busy | output | 1 | Conversion in progress |
| res_ready | output | 1 | One-cycle pulse when a result is loaded |
| clk_mode | output | 2 | Current clock mode |

## Verification
The checker applies several rules on every cycle:
- The request and ready pulses last a single cycle.
- Busy holds until done arrives.
- The output enable follows select.
- The result line stays still unless there is a load or a falling edge.
- A receive never begins while busy, or before the shift count reaches the mode's threshold.

Other behaviour can only be shown by the bench's scenarios. This covers command framing and decoding, span code 3 being ignored, the no-operation opcode, and the bit order of the result. It also covers the exact threshold edge in every mode, where a start one bit early is rejected and one at the threshold is accepted.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_CFG  = 2'b01,
    OP_CONV = 2'b10,
    OP_MODE = 2'b11
  } op_e;

  typedef struct packed {
    logic       diff;
    logic [1:0] span;
  } ch_cfg_t;

  localparam logic [1:0] SPAN_3X  = 2'd0;
  localparam logic [1:0] SPAN_BAD = 2'd3;

  localparam logic [1:0] MODE_EXT_CLK = 2'd0;
  localparam logic [1:0] MODE_EXT_ACQ = 2'd1;
  localparam logic [1:0] MODE_INT_CLK = 2'd2;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sel_n_i,
  input  logic cmd_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_active,
  output logic cmd_q
);

  // each stage holds {sclk, sel_n, cmd}
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [STAGES-1:0][2:0] pipe;
  logic                   sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe   <= {STAGES{IDLE_VAL}};
      sclk_d <= 1'b0;
    end else begin
      pipe[0] <= {sclk_i, sel_n_i, cmd_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_d <= pipe[STAGES-1][2];
    end
  end

  assign sclk_rise  = pipe[STAGES-1][2] & ~sclk_d;
  assign sclk_fall  = ~pipe[STAGES-1][2] & sclk_d;
  assign sel_active = ~pipe[STAGES-1][1];
  assign cmd_q      = pipe[STAGES-1][0];

endmodule

// File: rtl/adc_sif_cmd_rx.sv
module adc_sif_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             sel_active,
  input  logic             cmd_bit,
  input  logic             accept_ok,
  output logic             rx_busy,
  output logic             word_vld,
  output logic [CMD_W-1:0] word
);

  localparam int CW = $clog2(CMD_W);

  logic [CW-1:0]    cnt;
  logic [CMD_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_busy  <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (!sel_active) begin
        rx_busy <= 1'b0;
        cnt     <= '0;
      end else if (rise) begin
        if (!rx_busy) begin
          if (cmd_bit && accept_ok) begin
            rx_busy <= 1'b1;
            cnt     <= '0;
          end
        end else begin
          sh  <= {sh[CMD_W-3:0], cmd_bit};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CMD_W - 1)) begin
            rx_busy  <= 1'b0;
            word_vld <= 1'b1;
            word     <= {sh, cmd_bit};
          end
        end
      end
    end
  end

endmodule

// File: rtl/adc_sif_cfg_bank.sv
module adc_sif_cfg_bank
  import adc_sif_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CH_W-1:0] wsel,
  input  ch_cfg_t         wdata,
  input  logic [CH_W-1:0] rsel,
  output ch_cfg_t         rdata
);

  ch_cfg_t regs [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) regs[i] <= '{diff: 1'b0, span: SPAN_3X};
    end else if (we) begin
      regs[wsel] <= wdata;
    end
  end

  assign rdata = regs[rsel];

endmodule

// File: rtl/adc_sif_tx.sv
module adc_sif_tx #(
  parameter int RES_W = 14,
  parameter int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] res,
  input  logic             fall,
  input  logic             sel_active,
  output logic             dout,
  output logic [CNT_W-1:0] sent
);

  logic [RES_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      sent <= CNT_W'(RES_W);
    end else if (load) begin
      sh   <= res;
      sent <= '0;
    end else if (fall && sel_active && sent != CNT_W'(RES_W)) begin
      sh   <= {sh[RES_W-2:0], 1'b0};
      sent <= sent + 1'b1;
    end
  end

  assign dout = sh[RES_W-1];

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_sif_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CH_W        = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_sel_n,
  input  logic             ser_cmd,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             ser_res,
  output logic             ser_res_en,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_chan,
  output logic             conv_diff,
  output logic [1:0]       conv_span,
  output logic             conv_busy,
  output logic             res_ready,
  output logic [1:0]       clk_mode
);

  localparam int CMD_W = 2 + CH_W + 3;
  localparam int CNT_W = $clog2(RES_W + 1);

  logic             sclk_rise, sclk_fall, sel_active, cmd_q;
  logic             rx_busy, word_vld, accept_ok, tx_load, cfg_we;
  logic [CMD_W-1:0] word;
  logic [CNT_W-1:0] sent, thr;
  logic [CH_W-1:0]  w_chan;
  op_e              w_op;
  ch_cfg_t          w_cfg, rd_cfg;

  adc_sif_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .sclk_i(ser_clk), .sel_n_i(ser_sel_n), .cmd_i(ser_cmd),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sel_active(sel_active), .cmd_q(cmd_q)
  );

  // bits that must have left the result line before a new start is taken
  always_comb begin
    case (clk_mode)
      MODE_EXT_CLK: thr = CNT_W'(RES_W - 1);
      MODE_EXT_ACQ: thr = CNT_W'(RES_W - 5);
      MODE_INT_CLK: thr = CNT_W'(RES_W - 2);
      default:      thr = CNT_W'(RES_W);
    endcase
  end

  assign accept_ok = ~conv_busy && (sent >= thr);

  adc_sif_cmd_rx #(.CMD_W(CMD_W)) rx_i (
    .clk(clk), .rst(rst), .rise(sclk_rise), .sel_active(sel_active), .cmd_bit(cmd_q),
    .accept_ok(accept_ok), .rx_busy(rx_busy), .word_vld(word_vld), .word(word)
  );

  assign w_op   = op_e'(word[CMD_W-1 -: 2]);
  assign w_chan = word[CH_W+2:3];
  assign w_cfg  = '{diff: word[2], span: word[1:0]};
  assign cfg_we = word_vld && (w_op == OP_CFG) && (word[1:0] != SPAN_BAD);

  adc_sif_cfg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wsel(w_chan), .wdata(w_cfg),
    .rsel(w_chan), .rdata(rd_cfg)
  );

  assign tx_load = conv_done && conv_busy;

  adc_sif_tx #(.RES_W(RES_W), .CNT_W(CNT_W)) tx_i (
    .clk(clk), .rst(rst), .load(tx_load), .res(conv_data), .fall(sclk_fall),
    .sel_active(sel_active), .dout(ser_res), .sent(sent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_req   <= 1'b0;
      conv_chan  <= '0;
      conv_diff  <= 1'b0;
      conv_span  <= SPAN_3X;
      conv_busy  <= 1'b0;
      res_ready  <= 1'b0;
      clk_mode   <= MODE_EXT_CLK;
      ser_res_en <= 1'b0;
    end else begin
      conv_req   <= 1'b0;
      res_ready  <= 1'b0;
      ser_res_en <= sel_active;
      if (word_vld && w_op == OP_CONV && !conv_busy) begin
        conv_req  <= 1'b1;
        conv_chan <= w_chan;
        conv_diff <= rd_cfg.diff;
        conv_span <= rd_cfg.span;
        conv_busy <= 1'b1;
      end
      if (tx_load) begin
        conv_busy <= 1'b0;
        res_ready <= 1'b1;
      end
      if (word_vld && w_op == OP_MODE) clk_mode <= word[1:0];
    end
  end

endmodule

// File: rtl/adc_sif_chk.sv
module adc_sif_chk #(
  parameter int CNT_W = 4,
  parameter int RES_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_active,
  input logic             sclk_fall,
  input logic             tx_load,
  input logic             rx_busy,
  input logic             conv_busy,
  input logic             conv_done,
  input logic             conv_req,
  input logic             res_ready,
  input logic             ser_res,
  input logic             ser_res_en,
  input logic [CNT_W-1:0] sent,
  input logic [CNT_W-1:0] thr
);

  a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
    conv_busy && !conv_done |=> conv_busy);

  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (rst)
    res_ready |-> $past(conv_done) && $past(conv_busy));

  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    res_ready |=> !res_ready);

  a_r7_res_quiet: assert property (@(posedge clk) disable iff (rst)
    !tx_load && !(sclk_fall && sel_active) |=> $stable(ser_res));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    sent <= CNT_W'(RES_W));

  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_busy) |-> !$past(conv_busy));

  a_r9_start_threshold: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_busy) |-> $past(sent) >= $past(thr));

  a_r10_en_follows_sel: assert property (@(posedge clk) disable iff (rst)
    !sel_active |=> !ser_res_en);

endmodule

bind adc_serial_if adc_sif_chk #(.CNT_W(CNT_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst(rst), .sel_active(sel_active), .sclk_fall(sclk_fall),
  .tx_load(tx_load), .rx_busy(rx_busy), .conv_busy(conv_busy), .conv_done(conv_done),
  .conv_req(conv_req), .res_ready(res_ready), .ser_res(ser_res), .ser_res_en(ser_res_en),
  .sent(sent), .thr(thr)
);

// File: tb/adc_serial_if_tb.sv
module adc_serial_if_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_sel_n = 1'b1, ser_cmd = 1'b0;
  logic        conv_done = 1'b0;
  logic [13:0] conv_data = '0;
  logic        ser_res, ser_res_en, conv_req, conv_diff, conv_busy, res_ready;
  logic [2:0]  conv_chan;
  logic [1:0]  conv_span, clk_mode;

  int checks = 0, fails = 0, req_cnt = 0, rdy_cnt = 0;
  logic [2:0] req_chan;
  logic       req_diff;
  logic [1:0] req_span;
  bit         done_flag = 0;

  always #4 clk = ~clk;

  adc_serial_if dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .ser_cmd(ser_cmd),
    .conv_done(conv_done), .conv_data(conv_data), .ser_res(ser_res), .ser_res_en(ser_res_en),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_diff(conv_diff), .conv_span(conv_span),
    .conv_busy(conv_busy), .res_ready(res_ready), .clk_mode(clk_mode)
  );

  always @(negedge clk) if (!rst) begin
    if (conv_req) begin
      req_cnt++; req_chan = conv_chan; req_diff = conv_diff; req_span = conv_span;
    end
    if (res_ready) rdy_cnt++;
  end

  // {chan[22:20], diff[19], span[18:17], exp_diff[16], exp_span[15:14], result[13:0]}
  localparam logic [22:0] VEC [6] = '{
    {3'd1, 1'b1, 2'd1, 1'b1, 2'd1, 14'h2A5C},
    {3'd7, 1'b0, 2'd2, 1'b0, 2'd2, 14'h3FFF},
    {3'd1, 1'b0, 2'd3, 1'b1, 2'd1, 14'h0000},
    {3'd0, 1'b1, 2'd2, 1'b1, 2'd2, 14'h2000},
    {3'd5, 1'b1, 2'd0, 1'b1, 2'd0, 14'h1555},
    {3'd7, 1'b1, 2'd1, 1'b1, 2'd1, 14'h0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sbit(input logic b);
    ser_cmd = b; wclk(4); ser_clk = 1'b1; wclk(4); ser_clk = 1'b0;
  endtask

  task automatic send(input logic [7:0] w);
    sbit(1'b1);
    for (int i = 7; i >= 0; i--) sbit(w[i]);
    wclk(6);
  endtask

  task automatic pulse_done(input logic [13:0] r);
    conv_data = r; conv_done = 1'b1; wclk(1); conv_done = 1'b0; wclk(4);
  endtask

  task automatic readout(input logic [13:0] r, input string tag);
    for (int k = 13; k >= 0; k--) begin
      wclk(5);
      chk(tag, ser_res, r[k]);
      sbit(1'b0);
    end
    wclk(5);
    chk({tag, " tail"}, ser_res, 1'b0);
  endtask

  function automatic logic [7:0] cfg_w(input logic [2:0] ch, input logic d, input logic [1:0] s);
    return {2'b01, ch, d, s};
  endfunction
  function automatic logic [7:0] conv_w(input logic [2:0] ch);
    return {2'b10, ch, 3'b000};
  endfunction
  function automatic logic [7:0] mode_w(input logic [1:0] m);
    return {2'b11, 4'b0000, m};
  endfunction

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base;
    wclk(5); rst = 1'b0; wclk(3);
    // R1 reset state
    chk("R1 res_en", ser_res_en, 1'b0);
    chk("R1 busy", conv_busy, 1'b0);
    chk("R1 mode", clk_mode, 2'd0);
    ser_sel_n = 1'b0; wclk(6);
    chk("R10 res_en low sel", ser_res_en, 1'b1);
    // R2 leading zeros discarded, R1 reset setting seen on channel 3
    sbit(1'b0); sbit(1'b0); sbit(1'b0);
    send(conv_w(3'd3));
    chk("R1 req", req_cnt, 1);
    chk("R1 cfg", {req_chan, req_diff, req_span}, {3'd3, 1'b0, 2'd0});
    pulse_done(14'h0ABC);
    readout(14'h0ABC, "R7 first readout");

    // table of setting / conversion / readout vectors (R3 R4 R5 R6 R7)
    for (int v = 0; v < 6; v++) begin
      base = req_cnt;
      send(cfg_w(VEC[v][22:20], VEC[v][19], VEC[v][18:17]));
      send(conv_w(VEC[v][22:20]));
      chk("R5 req pulse", req_cnt, base + 1);
      chk("R4 cfg on request", {req_chan, req_diff, req_span},
          {VEC[v][22:20], VEC[v][16], VEC[v][15:14]});
      chk("R5 busy", conv_busy, 1'b1);
      base = rdy_cnt;
      pulse_done(VEC[v][13:0]);
      chk("R6 ready", rdy_cnt, base + 1);
      chk("R6 busy clear", conv_busy, 1'b0);
      readout(VEC[v][13:0], "R7 bit");
    end

    // R8 start rejected while busy
    send(conv_w(3'd2));
    base = req_cnt;
    send(conv_w(3'd4));
    chk("R8 no second req", req_cnt, base);
    chk("R8 still busy", conv_busy, 1'b1);
    pulse_done(14'h1B3D);
    readout(14'h1B3D, "R7 after busy");

    // R6 done while idle ignored
    base = rdy_cnt;
    pulse_done(14'h3FFF);
    chk("R6 idle done ready", rdy_cnt, base);
    chk("R6 idle done line", ser_res, 1'b0);
    chk("R6 idle done busy", conv_busy, 1'b0);

    // R12 no-operation opcode
    send({2'b00, 3'd7, 1'b0, 2'd2});
    chk("R12 mode kept", clk_mode, 2'd0);
    send(conv_w(3'd7));
    chk("R12 cfg kept", {req_diff, req_span}, {1'b1, 2'd1});
    pulse_done(14'h0F0F);
    readout(14'h0F0F, "R7 after nop");

    // R10 select high aborts partial word
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    ser_sel_n = 1'b1; wclk(6);
    chk("R10 res_en off", ser_res_en, 1'b0);
    ser_sel_n = 1'b0; wclk(6);
    send(mode_w(2'd2));
    chk("R10 abort then mode", clk_mode, 2'd2);

    // R9 per-mode acceptance threshold, R11 mode write
    for (int m = 0; m < 4; m++) begin
      int t;
      t = (m == 0) ? 13 : (m == 1) ? 9 : (m == 2) ? 12 : 14;
      send(mode_w(m[1:0]));
      chk("R11 mode", clk_mode, m);
      send(conv_w(3'd0));
      pulse_done(14'h1234);
      repeat (t - 1) sbit(1'b0);
      base = req_cnt;
      send(conv_w(3'd0));
      sbit(1'b0); wclk(6);
      chk("R9 early start rejected", req_cnt, base);
      send(conv_w(3'd0));
      pulse_done(14'h2345);
      repeat (t) sbit(1'b0);
      base = req_cnt;
      send(conv_w(3'd0));
      chk("R9 start at threshold", req_cnt, base + 1);
      pulse_done(14'h0001);
      repeat (14) sbit(1'b0);
    end

    wclk(10);
    summary();
  end

endmodule